// File: doc/BRIEF.md
# Function-Code-Tagged Data Cache Read Path

This block sits between a processor's operand port and its bus interface. It holds recently read operands in a small direct-mapped store. The store has 16 lines, and each line has four 32-bit long words. A single tag per line covers the upper address bits and the full 3-bit access class (function code). Each long word in a line has its own valid bit. Operand reads may be one, two or four bytes long, at any byte alignment. When an operand crosses a long-word boundary, the two long words it touches are looked up one after the other. Each of those two looks hits or misses on its own, and a miss fetches only that long word.

Only accesses that are cachable and are neither in the CPU address class (function code 7) nor translation-table walks leave anything behind in the store. The other accesses still complete, but they always go to the bus. On a miss, when the line holds nothing for the tag and bursts are allowed, the whole line is fetched. The burst starts at the needed long word and wraps around the line. Writes always go out to the bus. A write that hits also patches the addressed bytes in place, and a write that misses leaves the store untouched.

Top module: `fc_dcache`

## Requirements
- R1: A lookup hits only when the line chosen by address bits 7:4 has a tag whose 3-bit function code and address bits 31:8 both equal the access's. The valid bit chosen by address bits 3:2 must also be set. A hit performs no bus read.
- R2: A read miss performs one full-width bus read (busBe = 4'hF) of the needed long word. That word is kept only when reqCachable is 1. When the line already holds valid words of the same tag, only that one word is fetched, even with reqBurstOk set.
- R3: A storable read miss with reqBurstOk set, on a line holding no valid word for its tag, fetches four long words with busBurst high. The fetch starts at the needed word and wraps within the line. All four words are kept, so later reads of any of them hit.
- R4: Accesses with function code 7 are never kept and never burst, so repeating them reads the bus each time.
- R5: Reads with reqTableSearch set are fetched but not kept. A later ordinary read of the same word therefore still misses.
- R6: An operand that crosses a long-word boundary, even one that crosses into the next line, is checked as two independent entries. Any mix of hit and miss is allowed, and when both miss, two bus reads occur.
- R7: reqSize 0, 1 and 2/3 mean 1, 2 and 4 bytes. respData holds the operand right-aligned and zero-extended, with the byte at the lowest address most significant. respDone is a pulse one cycle long.
- R8: Every write goes to the bus once per touched long word. busBe[3] marks the byte at offset 0 and busBe[0] the byte at offset 3. A write hit updates only those bytes in the store. A write miss allocates nothing.
- R9: Reset clears every valid bit. While idle, reqReady is 1 and busReq is 0.
- R10: Once raised, busReq stays high with busAddr and busWrite steady until busAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Operand request, taken when reqReady is 1 |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 32 | Byte address of the operand |
| reqFc | input | 3 | Function code of the access |
| reqSize | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| reqCachable | input | 1 | Access may be kept in the store |
| reqTableSearch | input | 1 | Access is a translation-table walk |
| reqBurstOk | input | 1 | A line-filling burst is permitted |
| reqWdata | input | 32 | Write operand, right-aligned |
| respDone | output | 1 | Operation complete, one cycle |
| respData | output | 32 | Read operand, right-aligned |
| busReq | output | 1 | Bus cycle request |
| busWrite | output | 1 | Bus cycle is a write |
| busBurst | output | 1 | Bus read is part of a line burst |
| busAddr | output | 32 | Long-word aligned bus address |
| busFc | output | 3 | Function code of the bus cycle |
| busBe | output | 4 | Byte enables, bit 3 = offset 0 |
| busWdata | output | 32 | Write data in byte lanes |
| busAck | input | 1 | Bus cycle complete, read data valid |
| busRdata | input | 32 | Bus read data |

## Verification
If a tag, valid bit or fill decision is wrong, the fault shows up first in the number of bus reads an operand causes. It appears during that very operation, as either an extra fetch or a missing one. It does not wait until a wrong operand comes back later. Every vector therefore counts bus reads and writes next to the returned data. Bytes that are merged or patched in the wrong lane appear in respData on the next read of that word. Some vectors rely on exactly this: they read back words that were just written or filled by a burst, without any further bus traffic.

// File: rtl/fc_dcache_pkg.sv
package fc_dcache_pkg;
  localparam int WORD_SEL_W = 2;
  localparam int LINE_WORDS = 1 << WORD_SEL_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_FETCH, ST_WRITE, ST_DONE
  } dcState_e;

  typedef struct packed {
    logic                  latchReq;
    logic                  capture;
    logic                  captureBus;
    logic                  fillEn;
    logic                  updateEn;
    logic                  partSel;
    logic [WORD_SEL_W-1:0] beat;
  } dcStrobe_t;
endpackage

// File: rtl/fc_dcache_ctrl.sv
module fc_dcache_ctrl
  import fc_dcache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      isWrite,
  input  logic      hit,
  input  logic      twoParts,
  input  logic      burstNow,
  input  logic      busAck,
  output dcStrobe_t stb,
  output logic      reqReady,
  output logic      busReq,
  output logic      busWrite,
  output logic      busBurst,
  output logic      respDone
);
  dcState_e              st;
  logic                  partSel;
  logic                  burstMode;
  logic [WORD_SEL_W-1:0] beat;
  logic                  lastPart;

  assign lastPart = partSel || !twoParts;

  always_comb begin
    stb            = '0;
    stb.latchReq   = (st == ST_IDLE) && reqValid;
    stb.capture    = ((st == ST_LOOK) && !isWrite && hit) ||
                     ((st == ST_FETCH) && busAck && (beat == '0));
    stb.captureBus = (st == ST_FETCH);
    stb.fillEn     = (st == ST_FETCH) && busAck;
    stb.updateEn   = (st == ST_LOOK) && isWrite && hit;
    stb.partSel    = partSel;
    stb.beat       = beat;
  end

  assign reqReady = (st == ST_IDLE);
  assign busReq   = (st == ST_FETCH) || (st == ST_WRITE);
  assign busWrite = (st == ST_WRITE);
  assign busBurst = (st == ST_FETCH) && burstMode;
  assign respDone = (st == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      partSel   <= 1'b0;
      burstMode <= 1'b0;
      beat      <= '0;
    end else begin
      case (st)
        ST_IDLE: if (reqValid) begin
          st      <= ST_LOOK;
          partSel <= 1'b0;
        end
        ST_LOOK: begin
          beat <= '0;
          if (isWrite) st <= ST_WRITE;
          else if (hit) begin
            if (lastPart) st <= ST_DONE;
            else partSel <= 1'b1;
          end else begin
            st        <= ST_FETCH;
            burstMode <= burstNow;
          end
        end
        ST_FETCH: if (busAck) begin
          if (burstMode && (beat != '1)) beat <= beat + 1'b1;
          else if (lastPart) st <= ST_DONE;
          else begin
            partSel <= 1'b1;
            st      <= ST_LOOK;
          end
        end
        ST_WRITE: if (busAck) begin
          if (lastPart) st <= ST_DONE;
          else begin
            partSel <= 1'b1;
            st      <= ST_LOOK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fc_dcache_dpath.sv
module fc_dcache_dpath
  import fc_dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 16,
  parameter int FC_W   = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  dcStrobe_t         stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [FC_W-1:0]   reqFc,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqCachable,
  input  logic              reqTableSearch,
  input  logic              reqBurstOk,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       busRdata,
  output logic              isWrite,
  output logic              hit,
  output logic              twoParts,
  output logic              burstNow,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic [3:0]        busBe,
  output logic [31:0]       busWdata,
  output logic [31:0]       respData
);
  localparam int IDX_W = $clog2(LINES);
  localparam int LA_W  = ADDR_W - 2;
  localparam int TAG_W = LA_W - IDX_W - WORD_SEL_W;
  localparam int TFC_W = TAG_W + FC_W;

  logic [TFC_W-1:0]      tagMem   [LINES];
  logic [LINE_WORDS-1:0] validMem [LINES];
  logic [31:0]           dataMem  [LINES*LINE_WORDS];

  logic [ADDR_W-1:0] aReg;
  logic [FC_W-1:0]   fcReg;
  logic [1:0]        sizeReg;
  logic              cachReg, tsReg, burstOkReg;
  logic [31:0]       wdReg, partBuf0, partBuf1;

  logic [LA_W-1:0]       partLa;
  logic [IDX_W-1:0]      idx;
  logic [WORD_SEL_W-1:0] wsel, fillWord;
  logic [TFC_W-1:0]      curTag;
  logic                  bypass, storable, tagEq;
  logic [2:0]            nBytes;
  logic [1:0]            off;
  logic [7:0]            winMask;
  logic [3:0]            partMask;
  logic [5:0]            shAlign, shOff;
  logic [63:0]           wWin, rWin;
  logic [31:0]           partW;

  assign partLa   = aReg[ADDR_W-1:2] + LA_W'(stb.partSel);
  assign idx      = partLa[WORD_SEL_W +: IDX_W];
  assign wsel     = partLa[WORD_SEL_W-1:0];
  assign fillWord = wsel + stb.beat;
  assign curTag   = {fcReg, partLa[LA_W-1 -: TAG_W]};
  assign bypass   = (fcReg == '1) || tsReg;
  assign storable = cachReg && !bypass;
  assign tagEq    = (tagMem[idx] == curTag);
  assign hit      = !bypass && tagEq && validMem[idx][wsel];
  assign burstNow = burstOkReg && storable && (!tagEq || (validMem[idx] == '0));
  assign isWrite  = wrReg;

  logic wrReg;
  assign off      = aReg[1:0];
  assign nBytes   = (sizeReg == 2'd0) ? 3'd1 : (sizeReg == 2'd1) ? 3'd2 : 3'd4;
  assign twoParts = ({2'b00, off} + {1'b0, nBytes}) > 4'd4;
  assign winMask  = ~(8'hFF >> nBytes) >> off;
  assign partMask = stb.partSel ? winMask[3:0] : winMask[7:4];
  assign shAlign  = {nBytes == 3'd1 ? 3'd3 : nBytes == 3'd2 ? 3'd2 : 3'd0, 3'b000};
  assign shOff    = {1'b0, off, 3'b000};
  assign wWin     = ({wdReg, 32'h0} << shAlign) >> shOff;
  assign partW    = stb.partSel ? wWin[31:0] : wWin[63:32];
  assign rWin     = {partBuf0, partBuf1} << shOff;
  assign respData = rWin[63:32] >> shAlign;

  assign busAddr  = {partLa[LA_W-1:WORD_SEL_W], fillWord, 2'b00};
  assign busFc    = fcReg;
  assign busBe    = wrReg ? partMask : 4'hF;
  assign busWdata = partW;

  always_ff @(posedge clk) begin
    if (stb.latchReq) begin
      aReg       <= reqAddr;
      fcReg      <= reqFc;
      sizeReg    <= reqSize;
      wrReg      <= reqWrite;
      cachReg    <= reqCachable;
      tsReg      <= reqTableSearch;
      burstOkReg <= reqBurstOk;
      wdReg      <= reqWdata;
    end
    if (stb.capture) begin
      if (stb.partSel) partBuf1 <= stb.captureBus ? busRdata : dataMem[{idx, wsel}];
      else             partBuf0 <= stb.captureBus ? busRdata : dataMem[{idx, wsel}];
    end
    if (stb.fillEn && storable) dataMem[{idx, fillWord}] <= busRdata;
    if (stb.updateEn) begin
      for (int b = 0; b < 4; b++)
        if (partMask[b]) dataMem[{idx, wsel}][8*b +: 8] <= partW[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        validMem[i] <= '0;
        tagMem[i]   <= '0;
      end
    end else if (stb.fillEn && storable) begin
      if (tagEq) validMem[idx][fillWord] <= 1'b1;
      else begin
        validMem[idx] <= LINE_WORDS'(1) << fillWord;
        tagMem[idx]   <= curTag;
      end
    end
  end
endmodule

// File: rtl/fc_dcache.sv
module fc_dcache
  import fc_dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 16,
  parameter int FC_W   = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [FC_W-1:0]   reqFc,
  input  logic [1:0]        reqSize,
  input  logic              reqCachable,
  input  logic              reqTableSearch,
  input  logic              reqBurstOk,
  input  logic [31:0]       reqWdata,
  output logic              respDone,
  output logic [31:0]       respData,
  output logic              busReq,
  output logic              busWrite,
  output logic              busBurst,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic [3:0]        busBe,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic [31:0]       busRdata
);
  dcStrobe_t stb;
  logic isWrite, hit, twoParts, burstNow;

  fc_dcache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isWrite(isWrite), .hit(hit),
    .twoParts(twoParts), .burstNow(burstNow), .busAck(busAck), .stb(stb),
    .reqReady(reqReady), .busReq(busReq), .busWrite(busWrite),
    .busBurst(busBurst), .respDone(respDone)
  );

  fc_dcache_dpath #(.ADDR_W(ADDR_W), .LINES(LINES), .FC_W(FC_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqFc(reqFc),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqCachable(reqCachable),
    .reqTableSearch(reqTableSearch), .reqBurstOk(reqBurstOk), .reqWdata(reqWdata),
    .busRdata(busRdata), .isWrite(isWrite), .hit(hit), .twoParts(twoParts),
    .burstNow(burstNow), .busAddr(busAddr), .busFc(busFc), .busBe(busBe),
    .busWdata(busWdata), .respData(respData)
  );
endmodule

// File: rtl/fc_dcache_chk.sv
module fc_dcache_chk #(
  parameter int ADDR_W = 32,
  parameter int FC_W   = 3
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              respDone,
  input logic              busReq,
  input logic              busAck,
  input logic              busWrite,
  input logic              busBurst,
  input logic [ADDR_W-1:0] busAddr,
  input logic [FC_W-1:0]   busFc,
  input logic [3:0]        busBe
);
  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWrite));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busReq && !respDone);
  p_cpu_noburst_r4: assert property (@(posedge clk) disable iff (!rstN)
    busReq && (busFc == '1) |-> !busBurst);
  p_read_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWrite |-> busBe == 4'hF);
  p_write_be_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWrite |-> (busBe != 4'h0) && !busBurst);
  p_burst_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    busBurst |-> busReq && !busWrite);
endmodule

bind fc_dcache fc_dcache_chk #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (.*);

// File: tb/fc_dcache_tb.sv
`timescale 1ns/1ps
module fc_dcache_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqCachable = 1'b0;
  logic reqTableSearch = 1'b0, reqBurstOk = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [2:0]  reqFc = '0;
  logic [1:0]  reqSize = '0;
  logic reqReady, respDone, busReq, busWrite, busBurst;
  logic [31:0] respData, busAddr, busWdata;
  logic [2:0]  busFc;
  logic [3:0]  busBe;
  logic busAck = 1'b0;
  logic [31:0] busRdata = '0;

  always #4 clk = ~clk;

  fc_dcache u_dut (.*);

  logic [31:0] mem [1024];
  int rdCnt, wrCnt, checks, fails;
  logic [3:0] firstBe;

  initial for (int i = 0; i < 1024; i++) mem[i] = (32'h9E37_79B1 * i) ^ 32'h5A5A_0F0F;

  // bus model: answers one cycle after each request edge
  always @(negedge clk) begin
    if (busReq && !busAck) begin
      busAck = 1'b1;
      if (busWrite) begin
        if (wrCnt == 0) firstBe = busBe;
        wrCnt++;
        for (int b = 0; b < 4; b++)
          if (busBe[b]) mem[busAddr[11:2]][8*b +: 8] = busWdata[8*b +: 8];
      end else begin
        rdCnt++;
        busRdata = mem[busAddr[11:2]];
      end
    end else busAck = 1'b0;
  end

  function automatic logic [31:0] refRead(logic [31:0] a, logic [1:0] sz);
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] ba = a + i;
      r = (r << 8) | 32'(mem[ba[11:2]][8*(3-int'(ba[1:0])) +: 8]);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  logic [31:0] gotData;
  bit timedOut;

  task automatic doReq(input logic wr, input logic [31:0] a, input logic [2:0] fc,
                       input logic [1:0] sz, input logic c, input logic ts,
                       input logic bo, input logic [31:0] wd);
    int guard = 0;
    timedOut = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    rdCnt = 0; wrCnt = 0; firstBe = '0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqFc = fc; reqSize = sz;
    reqCachable = c; reqTableSearch = ts; reqBurstOk = bo; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respDone && guard < 64) begin @(negedge clk); guard++; end
    if (!respDone) timedOut = 1;
    gotData = respData;
  endtask

  typedef struct packed {
    logic wr; logic [31:0] addr; logic [2:0] fc; logic [1:0] sz;
    logic cach; logic ts; logic burst; logic [31:0] wd;
    logic [3:0] expRd; logic [3:0] expWr; logic [3:0] expBe; logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h1000, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd1, 4'd0, 4'h0, 4'd2}, // R2 cold miss
    '{1'b0, 32'h1000, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 4'h0, 4'd1}, // R1 hit
    '{1'b0, 32'h1006, 3'd5, 2'd1, 1'b1, 1'b0, 1'b1, 32'h0, 4'd1, 4'd0, 4'h0, 4'd2}, // R2 single fill
    '{1'b0, 32'h1006, 3'd5, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0, 4'd1, 4'd0, 4'h0, 4'd6}, // R6 hit+miss
    '{1'b0, 32'h1006, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 4'h0, 4'd6}, // R6 both hit
    '{1'b0, 32'h1003, 3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, 4'd1, 4'd0, 4'h0, 4'd1}, // R1 fc mismatch
    '{1'b0, 32'h1000, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd1, 4'd0, 4'h0, 4'd1}, // R1 replaced
    '{1'b0, 32'h1000, 3'd7, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0, 4'd1, 4'd0, 4'h0, 4'd4}, // R4
    '{1'b0, 32'h1000, 3'd7, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd1, 4'd0, 4'h0, 4'd4}, // R4 not kept
    '{1'b0, 32'h1020, 3'd5, 2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 4'd1, 4'd0, 4'h0, 4'd5}, // R5
    '{1'b0, 32'h1020, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd1, 4'd0, 4'h0, 4'd5}, // R5 not kept
    '{1'b0, 32'h1020, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 4'h0, 4'd5}, // R5 now kept
    '{1'b0, 32'h1040, 3'd5, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0, 4'd1, 4'd0, 4'h0, 4'd2}, // R2 uncachable
    '{1'b0, 32'h1040, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd1, 4'd0, 4'h0, 4'd2}, // R2 was not kept
    '{1'b0, 32'h2058, 3'd5, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0, 4'd4, 4'd0, 4'h0, 4'd3}, // R3 burst
    '{1'b0, 32'h2050, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 4'h0, 4'd3}, // R3 wrapped
    '{1'b0, 32'h205C, 3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 4'h0, 4'd3}, // R3
    '{1'b0, 32'h207E, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd2, 4'd0, 4'h0, 4'd6}, // R6 across line
    '{1'b1, 32'h2052, 3'd5, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_BEEF, 4'd0, 4'd1, 4'h3, 4'd8}, // R8
    '{1'b0, 32'h2050, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 4'h0, 4'd8}, // R8 patched
    '{1'b1, 32'h3000, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'hCAFE_F00D, 4'd0, 4'd1, 4'hF, 4'd8}, // R8 miss
    '{1'b0, 32'h3000, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd1, 4'd0, 4'h0, 4'd8}, // R8 no alloc
    '{1'b1, 32'h205E, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h1122_3344, 4'd0, 4'd2, 4'h3, 4'd8}, // R8 split
    '{1'b0, 32'h205C, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 4'h0, 4'd8}, // R8
    '{1'b0, 32'h205D, 3'd5, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0, 4'd0, 4'd0, 4'h0, 4'd7}, // R7 odd word
    '{1'b0, 32'h206F, 3'd5, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0, 4'd2, 4'd0, 4'h0, 4'd6}  // R6 both miss
  };

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    checks = 0; fails = 0;
    repeat (2) @(negedge clk);
    // R9 reset state
    check(reqReady && !busReq && !respDone, "R9 reset outputs", {busReq, respDone}, 32'h0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      doReq(VEC[v].wr, VEC[v].addr, VEC[v].fc, VEC[v].sz, VEC[v].cach, VEC[v].ts,
            VEC[v].burst, VEC[v].wd);
      check(!timedOut, $sformatf("R%0d v%0d done", VEC[v].req, v), 32'(timedOut), 32'h0);
      check(rdCnt == int'(VEC[v].expRd), $sformatf("R%0d v%0d bus reads", VEC[v].req, v),
            32'(rdCnt), 32'(VEC[v].expRd));
      check(wrCnt == int'(VEC[v].expWr), $sformatf("R%0d v%0d bus writes", VEC[v].req, v),
            32'(wrCnt), 32'(VEC[v].expWr));
      if (VEC[v].wr)
        check(firstBe == VEC[v].expBe, $sformatf("R%0d v%0d byte enables", VEC[v].req, v),
              32'(firstBe), 32'(VEC[v].expBe));
      else
        check(gotData == refRead(VEC[v].addr, VEC[v].sz),
              $sformatf("R%0d v%0d data", VEC[v].req, v), gotData, refRead(VEC[v].addr, VEC[v].sz));
      if (v == 24) begin
        @(negedge clk);
        check(!respDone, "R7 done pulse width", 32'(respDone), 32'h0);
      end
    end

    // R9 reset clears all valid bits: a previously hitting word misses
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doReq(1'b0, 32'h205C, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0);
    check(rdCnt == 1, "R9 miss after reset", 32'(rdCnt), 32'd1);
    check(gotData == refRead(32'h205C, 2'd2), "R9 data after reset", gotData, refRead(32'h205C, 2'd2));
    finishRun();
  end
endmodule